// File: doc/BRIEF.md
# Bipolar line code violation counter

This block watches a dual-rail bipolar receive stream and counts line coding errors. Each bit time is marked by a one-cycle bit enable. A positive mark raises the positive rail, a negative mark raises the negative rail, and a space leaves both rails low. Two marks in a row with the same polarity form a bipolar violation, and each one adds to a saturating 16-bit running count. A bit with both rails high is also counted as a violation.

When zero-substitution decoding is on, the block recognises the eight-bit substitution code word and does not count the two violations inside it. Every other violation is still counted. An option also counts runs of consecutive spaces. The run length is 16 spaces with substitution off and 8 spaces with it on.

A host pulses a latch input to capture the count into a readable register, split into a high byte and a low byte. The same pulse restarts the running count without losing an event. A one-cycle strobe marks every cycle in which the count grows.

Top module: `lcv_counter`

## Requirements
- R1: With `subst_en`=0, a mark whose polarity equals that of the previous single-rail mark adds 1 to the count. A mark is `pos_in`=1,`neg_in`=0 (positive) or `pos_in`=0,`neg_in`=1 (negative); a space is both rails 0. Alternating marks add nothing.
- R2: A bit with `pos_in`=1 and `neg_in`=1 counts as one violation and leaves the reference polarity unchanged.
- R3: With `subst_en`=1, a code word `000VB0VB` is not counted. In the code word, 0 is a space, V is a mark with the same polarity as the previous mark, and B is an alternating mark. A violation outside a code word is still counted, but it joins the count 5 bit times after it arrives.
- R4: Runs of spaces add to the count only while `zeros_en`=1.
- R5: A run of spaces counts as one event once it reaches 16 spaces with `subst_en`=0, or 8 spaces with `subst_en`=1. The run length then restarts, so a longer run gives one event per full threshold.
- R6: The running count saturates at 65535 and does not wrap.
- R7: A `snap` pulse loads the readable register with the running count plus any event of that same cycle, and sets the running count to 0. `cnt_hi` holds bits 15:8 and `cnt_lo` holds bits 7:0. Between pulses the readable register holds its value.
- R8: `evt` is high for exactly the one cycle after a cycle in which the count grew.
- R9: While `bit_en`=0 the rails are ignored: no count, no polarity update and no change to the run of spaces.
- R10: After reset the readable register, the running count and `evt` are 0, and no previous polarity exists, so the first mark is never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One line bit is present on the rails this cycle |
| pos_in | input | 1 | Positive rail |
| neg_in | input | 1 | Negative rail |
| subst_en | input | 1 | Zero-substitution decoding on |
| zeros_en | input | 1 | Also count runs of spaces |
| snap | input | 1 | Latch the count and restart it |
| cnt_hi | output | 8 | Readable count, bits 15:8 |
| cnt_lo | output | 8 | Readable count, bits 7:0 |
| evt | output | 1 | The count grew in the previous cycle |

## Verification
A violation with substitution off, a dual-rail bit and a run of spaces that reaches its threshold all add to the running count at the clock edge that samples the bit. The strobe rises at that same edge, so the bench samples it at the following falling edge. With substitution on, a violation joins the count only 5 bit times later, so the bench sends at least eight alternating flush marks before each latch. The readable bytes change only at the edge that samples `snap`. The scoreboard queues the expected value when it raises `snap` and compares at the next falling edge.

// File: rtl/lcv_counter.sv
module lcv_counter #(
  parameter int ZS_RUN    = 8,
  parameter int PLAIN_RUN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       pos_in,
  input  logic       neg_in,
  input  logic       subst_en,
  input  logic       zeros_en,
  input  logic       snap,
  output logic [7:0] cnt_hi,
  output logic [7:0] cnt_lo,
  output logic       evt
);
  localparam int ZW = $clog2(PLAIN_RUN + 1);
  localparam logic [1:0] C_ZERO = 2'd0, C_MARK = 2'd1, C_VIOL = 2'd2, C_DUAL = 2'd3;

  logic        last_pos, seen_mark;
  logic [15:0] hist, win, win_fix;
  logic [1:0]  cls;
  logic [ZW-1:0] zrun, zthr;
  logic [15:0] run_cnt, hold_cnt, next_cnt;
  logic [16:0] sum;
  logic [1:0]  inc;
  logic        cw_match, viol_hit, zhit;

  always_comb begin
    if (pos_in && neg_in)                          cls = C_DUAL;
    else if (pos_in || neg_in)                     cls = (seen_mark && pos_in == last_pos) ? C_VIOL : C_MARK;
    else                                           cls = C_ZERO;
  end

  assign win = {hist[13:0], cls};
  assign cw_match = subst_en &&
                    win[15:14] == C_ZERO && win[13:12] == C_ZERO && win[11:10] == C_ZERO &&
                    win[9:8]   == C_VIOL && win[7:6]   == C_MARK && win[5:4]   == C_ZERO &&
                    win[3:2]   == C_VIOL && win[1:0]   == C_MARK;
  assign win_fix  = cw_match ? {win[15:10], C_MARK, win[7:4], C_MARK, win[1:0]} : win;
  assign viol_hit = subst_en ? win[11] : cls[1];

  assign zthr = subst_en ? ZW'(ZS_RUN) : ZW'(PLAIN_RUN);
  assign zhit = (cls == C_ZERO) && (zrun + 1'b1 >= zthr);

  assign inc      = bit_en ? {1'b0, viol_hit} + {1'b0, zeros_en & zhit} : 2'd0;
  assign sum      = {1'b0, run_cnt} + {15'd0, inc};
  assign next_cnt = sum[16] ? 16'hFFFF : sum[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_pos  <= 1'b0;
      seen_mark <= 1'b0;
      hist      <= '0;
      zrun      <= '0;
    end else if (bit_en) begin
      hist <= win_fix;
      if (pos_in ^ neg_in) begin
        last_pos  <= pos_in;
        seen_mark <= 1'b1;
      end
      if (cls != C_ZERO)  zrun <= '0;
      else if (zhit)      zrun <= '0;
      else                zrun <= zrun + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      hold_cnt <= '0;
      evt      <= 1'b0;
    end else begin
      evt <= (inc != 2'd0);
      if (snap) begin
        hold_cnt <= next_cnt;
        run_cnt  <= '0;
      end else begin
        run_cnt  <= next_cnt;
      end
    end
  end

  assign cnt_hi = hold_cnt[15:8];
  assign cnt_lo = hold_cnt[7:0];

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> run_cnt >= $past(run_cnt));
  assert_snap_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> run_cnt == 16'd0);
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(hold_cnt));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !snap) |=> ($stable(run_cnt) && $stable(zrun) && !evt));
  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zrun < ZW'(PLAIN_RUN));
  assert_evt_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(bit_en));
endmodule

// File: tb/lcv_counter_tb.sv
module lcv_counter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 0, pos_in = 0, neg_in = 0, subst_en = 0, zeros_en = 0, snap = 0;
  logic [7:0] cnt_hi, cnt_lo;
  logic evt;
  int checks = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];
  logic snap_seen = 1'b0;
  logic lastp = 1'b0;

  always #4 clk = ~clk;

  lcv_counter u_dut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pos_in(pos_in), .neg_in(neg_in),
    .subst_en(subst_en), .zeros_en(zeros_en), .snap(snap), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .evt(evt));

  always @(posedge clk) snap_seen <= snap;

  always @(negedge clk) begin
    if (snap_seen && exp_q.size() > 0) begin
      automatic int e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      if (e >= 0) begin
        checks++;
        if ({cnt_hi, cnt_lo} != 16'(e)) begin
          errors++;
          $display("FAIL %s: count %0d expected %0d", t, {cnt_hi, cnt_lo}, e);
        end
      end
    end
  end

  task automatic mk(input logic p);
    @(negedge clk); bit_en = 1; pos_in = p; neg_in = !p; lastp = p;
  endtask
  task automatic zero(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_en = 1; pos_in = 0; neg_in = 0;
    end
  endtask
  task automatic dual();
    @(negedge clk); bit_en = 1; pos_in = 1; neg_in = 1;
  endtask
  task automatic alt(input int n);
    for (int i = 0; i < n; i++) mk(!lastp);
  endtask
  task automatic latch(input int e, input string t);
    @(negedge clk); bit_en = 0; pos_in = 0; neg_in = 0;
    exp_q.push_back(e); tag_q.push_back(t); snap = 1;
    @(negedge clk); snap = 0;
  endtask
  task automatic check1(input logic act, input logic ex, input string t);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: value %0b expected %0b", t, act, ex);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check1(evt, 1'b0, "R10 evt after reset");
    latch(0, "R10 count after reset");
    mk(1); mk(1); latch(1, "R10 first mark clean, then R1 repeat");
    alt(4); latch(0, "R1 alternating marks");
    mk(lastp); zero(1); mk(lastp); alt(2); latch(2, "R1 violations across space");
    dual(); mk(!lastp); latch(1, "R2 dual rail, polarity kept");
    dual(); @(negedge clk); bit_en = 0; pos_in = 0; neg_in = 0;
    check1(evt, 1'b1, "R8 evt after violation");
    @(negedge clk); check1(evt, 1'b0, "R8 evt one cycle");
    latch(1, "R8 count");
    @(negedge clk); bit_en = 0; pos_in = 1; neg_in = 1;
    @(negedge clk); pos_in = 1; neg_in = 0;
    @(negedge clk); pos_in = 1; neg_in = 0;
    latch(0, "R9 rails ignored");
    @(negedge clk); bit_en = 1; pos_in = 1; neg_in = 1; snap = 1;
    exp_q.push_back(1); tag_q.push_back("R7 same-cycle event kept");
    @(negedge clk); snap = 0; bit_en = 0; pos_in = 0; neg_in = 0;
    latch(0, "R7 running cleared");
    alt(1); zero(16); alt(1); latch(0, "R4 zeros ignored when off");
    zeros_en = 1;
    zero(16); alt(1); latch(1, "R5 sixteen spaces");
    zero(15); alt(1); latch(0, "R5 fifteen spaces");
    zero(32); alt(1); latch(2, "R5 run restarts");
    subst_en = 1; alt(8); latch(-1, "mode switch");
    zero(8); alt(8); latch(1, "R5 eight spaces with substitution");
    zero(7); alt(8); latch(0, "R5 seven spaces with substitution");
    zero(3); mk(lastp); mk(!lastp); zero(1); mk(lastp); mk(!lastp); alt(8);
    latch(0, "R3 code word not counted");
    mk(lastp); alt(4); latch(0, "R3 violation not yet due");
    alt(8); latch(1, "R3 isolated violation counted late");
    subst_en = 0; zeros_en = 0; alt(8); latch(-1, "mode switch");
    repeat (70000) dual();
    latch(65535, "R6 saturation");
    latch(0, "R6 cleared after saturation");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule